// File: doc/BRIEF.md
# Four-Channel Pulse-Width Modulator with Period-Aligned Commit

This block produces four independent pulse-width modulated outputs. Software programs each channel through a small memory-mapped register port, which has a write strobe, a read strobe, an address, write data and read data. Each channel has three settings: a prescale value, which stretches every count step to several clock cycles; a period modulus, in count steps; and a high time, also in count steps. An enable bit starts and stops the channel.

The prescale and modulus registers only stage new values. A write to the duty register commits the staged prescale and modulus together with the new duty. A running channel finishes its current period with the settings it started the period with, and only then switches over, so no period mixes old and new settings. Clearing the enable bit is the exception: it halts the channel at once, in the middle of a period if need be, and forces the output low.

Top module: `pwm_bank`

## Requirements
- R1: Address bits [6:5] select the channel and bits [4:0] select the register within that channel's 32-byte window. The registers are: prescale at 0x00 (8 bits), modulus at 0x04 (8 bits), duty at 0x08 (16 bits) and enable at 0x18 (bit 0). A read returns the last value written, masked to the field width, with all other bits zero.
- R2: A read of any other offset in a window (for example 0x0C, 0x10, 0x14, 0x1C or 0x01) returns zero. A write to such an offset changes no register and no output.
- R3: After reset, every register reads zero and every output is low.
- R4: While a channel is disabled, its output stays low.
- R5: A write of 1 to enable starts a fresh period in the cycle after the write. With committed values P, M and D, each period lasts (P+1)*M cycles. The output is high for the first (P+1)*min(D,M) cycles of each period.
- R6: A duty of zero gives a constant low output. A duty greater than or equal to the modulus gives a constant high output. A modulus of zero gives a constant low output.
- R7: Writes to prescale or modulus have no effect on the output until the duty register is written. They still read back as the staged values.
- R8: A duty write to a running channel takes effect at the next period start. The current period completes with the old prescale, modulus and duty.
- R9: A duty write to a disabled channel is applied before the next enable, so the first period after that enable uses the new values.
- R10: A write of 0 to enable drives the output low in the next cycle, even in mid-period. A later enable starts again from the beginning of a period.
- R11: Channels run independently. Writes to one channel never change another channel's output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; it also drives the count steps |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| addr_i | input | 7 | Byte address: channel in [6:5], register offset in [4:0] |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data; combinational and valid while bus_rd_i is high, zero otherwise |
| pwm_o | output | 4 | One modulated output per channel |

## Verification
The assertions check, on every cycle, the behaviours that depend only on the current state of a channel. They cover the low output and cleared counters while a channel is disabled, the counter bounds within a period, the high output at the start of each period, and the constant levels for a zero duty, a full duty and a zero modulus. They also check that the active settings stay stable between period boundaries, that a disable write leaves the output low in the next cycle, and that a read of an unmapped offset returns zero.

Other properties span many cycles and depend on history, and only the bench scenarios show them. These are the exact period and high-time lengths for each prescale, modulus and duty combination, the fact that staged prescale and modulus writes are deferred across whole periods, the exact cycle at which a mid-period commit takes effect, and the independence of the channels. The bench checks these against its own cycle-position model of every channel.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

  // Channel windows are 32 bytes apart.
  localparam int CH_SHIFT = 5;

  localparam logic [CH_SHIFT-1:0] OFF_PRESCALE = 5'h00;
  localparam logic [CH_SHIFT-1:0] OFF_MODULUS  = 5'h04;
  localparam logic [CH_SHIFT-1:0] OFF_DUTY     = 5'h08;
  localparam logic [CH_SHIFT-1:0] OFF_ENABLE   = 5'h18;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_PRESCALE,
    SEL_MODULUS,
    SEL_DUTY,
    SEL_ENABLE
  } reg_sel_e;

  // Exact match on the whole in-window offset; anything else is unmapped.
  function automatic reg_sel_e decode_offset(input logic [CH_SHIFT-1:0] off);
    case (off)
      OFF_PRESCALE: return SEL_PRESCALE;
      OFF_MODULUS:  return SEL_MODULUS;
      OFF_DUTY:     return SEL_DUTY;
      OFF_ENABLE:   return SEL_ENABLE;
      default:      return SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/pwm_addr_decode.sv
module pwm_addr_decode
  import pwm_bank_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int CH_W = 2,
  parameter int ADDR_W = CH_SHIFT + CH_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [CH_W-1:0]   ch_o,
  output reg_sel_e          sel_o,
  output logic              hit_o
);

  assign ch_o  = addr_i[ADDR_W-1:CH_SHIFT];
  assign sel_o = decode_offset(addr_i[CH_SHIFT-1:0]);

  generate
    if (NCH == (1 << CH_W)) begin : g_full
      assign hit_o = (sel_o != SEL_NONE);
    end else begin : g_partial
      assign hit_o = (sel_o != SEL_NONE) && (int'(ch_o) < NCH);
    end
  endgenerate

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
  parameter int PS_W    = 8,
  parameter int MOD_W   = 8,
  parameter int DUTY_W  = 16,
  parameter int FIELD_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_ps_i,
  input  logic               wr_mod_i,
  input  logic               wr_duty_i,
  input  logic               wr_en_i,
  input  logic [FIELD_W-1:0] wdata_i,
  output logic [PS_W-1:0]    ps_o,
  output logic [MOD_W-1:0]   mod_o,
  output logic [DUTY_W-1:0]  duty_o,
  output logic               en_o,
  output logic               pwm_o
);

  // Staged (software-visible) and active (running) settings.
  logic [PS_W-1:0]   sh_ps_q, act_ps_q, ps_cnt_q;
  logic [MOD_W-1:0]  sh_mod_q, act_mod_q, per_cnt_q;
  logic [DUTY_W-1:0] sh_duty_q, act_duty_q;
  logic              en_q, pend_q;

  // Last count step of a period; a zero modulus ends the period at every step.
  function automatic logic last_step(input logic [MOD_W-1:0] cnt,
                                     input logic [MOD_W-1:0] m);
    return ({1'b0, cnt} + (MOD_W+1)'(1)) >= {1'b0, m};
  endfunction

  // Output level at a given count step.
  function automatic logic level_at(input logic [MOD_W-1:0]  cnt,
                                    input logic [MOD_W-1:0]  m,
                                    input logic [DUTY_W-1:0] d);
    if (m == '0) return 1'b0;
    return DUTY_W'(cnt) < d;
  endfunction

  // Named internal events.
  logic step_tick, period_end, stop_req, run, load;

  assign step_tick  = (ps_cnt_q == act_ps_q);
  assign period_end = en_q && step_tick && last_step(per_cnt_q, act_mod_q);
  assign stop_req   = wr_en_i && !wdata_i[0];
  assign run        = en_q && !stop_req;
  assign load       = pend_q && (!en_q || period_end);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_ps_q    <= '0;
      sh_mod_q   <= '0;
      sh_duty_q  <= '0;
      act_ps_q   <= '0;
      act_mod_q  <= '0;
      act_duty_q <= '0;
      ps_cnt_q   <= '0;
      per_cnt_q  <= '0;
      en_q       <= 1'b0;
      pend_q     <= 1'b0;
    end else begin
      if (wr_ps_i)   sh_ps_q   <= wdata_i[PS_W-1:0];
      if (wr_mod_i)  sh_mod_q  <= wdata_i[MOD_W-1:0];
      if (wr_duty_i) sh_duty_q <= wdata_i[DUTY_W-1:0];
      if (wr_en_i)   en_q      <= wdata_i[0];

      if (wr_duty_i)  pend_q <= 1'b1;
      else if (load)  pend_q <= 1'b0;

      if (load) begin
        act_ps_q   <= sh_ps_q;
        act_mod_q  <= sh_mod_q;
        act_duty_q <= sh_duty_q;
      end

      if (!run) begin
        ps_cnt_q  <= '0;
        per_cnt_q <= '0;
      end else if (step_tick) begin
        ps_cnt_q  <= '0;
        per_cnt_q <= period_end ? '0 : per_cnt_q + MOD_W'(1);
      end else begin
        ps_cnt_q  <= ps_cnt_q + PS_W'(1);
      end
    end
  end

  assign ps_o   = sh_ps_q;
  assign mod_o  = sh_mod_q;
  assign duty_o = sh_duty_q;
  assign en_o   = en_q;
  assign pwm_o  = en_q && level_at(per_cnt_q, act_mod_q, act_duty_q);

  // ---------------- assertions ----------------
  assert_off_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |-> !pwm_o);

  assert_off_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |-> (ps_cnt_q == '0 && per_cnt_q == '0));

  assert_cnt_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && act_mod_q != '0) |-> (per_cnt_q < act_mod_q && ps_cnt_q <= act_ps_q));

  assert_start_high_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && per_cnt_q == '0 && act_mod_q != '0 && act_duty_q != '0) |-> pwm_o);

  assert_zero_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_duty_q == '0 || act_mod_q == '0) |-> !pwm_o);

  assert_full_high_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && act_mod_q != '0 && act_duty_q >= DUTY_W'(act_mod_q)) |-> pwm_o);

  assert_hold_midperiod_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && !period_end) |=> ($stable(act_ps_q) && $stable(act_mod_q) && $stable(act_duty_q)));

  assert_stop_now_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_req |=> (!pwm_o && ps_cnt_q == '0 && per_cnt_q == '0));

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int PS_W   = 8,
  parameter int MOD_W  = 8,
  parameter int DUTY_W = 16,
  parameter int DATA_W = 32,
  localparam int CH_W   = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int ADDR_W = CH_SHIFT + CH_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [NCH-1:0]    pwm_o
);

  localparam int FIELD_W = (DUTY_W > PS_W) ? ((DUTY_W > MOD_W) ? DUTY_W : MOD_W)
                                           : ((PS_W > MOD_W) ? PS_W : MOD_W);

  logic [CH_W-1:0] ch;
  reg_sel_e        sel;
  logic            hit;

  pwm_addr_decode #(.NCH(NCH), .CH_W(CH_W), .ADDR_W(ADDR_W)) u_decode (
    .addr_i (addr_i),
    .ch_o   (ch),
    .sel_o  (sel),
    .hit_o  (hit)
  );

  wire unused_wdata_hi = ^wdata_i[DATA_W-1:FIELD_W];

  logic [PS_W-1:0]   rb_ps   [NCH];
  logic [MOD_W-1:0]  rb_mod  [NCH];
  logic [DUTY_W-1:0] rb_duty [NCH];
  logic [NCH-1:0]    rb_en;

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      logic sel_ch;
      assign sel_ch = bus_wr_i && hit && (ch == CH_W'(i));

      pwm_channel #(
        .PS_W(PS_W), .MOD_W(MOD_W), .DUTY_W(DUTY_W), .FIELD_W(FIELD_W)
      ) u_chan (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_ps_i   (sel_ch && sel == SEL_PRESCALE),
        .wr_mod_i  (sel_ch && sel == SEL_MODULUS),
        .wr_duty_i (sel_ch && sel == SEL_DUTY),
        .wr_en_i   (sel_ch && sel == SEL_ENABLE),
        .wdata_i   (wdata_i[FIELD_W-1:0]),
        .ps_o      (rb_ps[i]),
        .mod_o     (rb_mod[i]),
        .duty_o    (rb_duty[i]),
        .en_o      (rb_en[i]),
        .pwm_o     (pwm_o[i])
      );
    end
  endgenerate

  always_comb begin
    rdata_o = '0;
    if (bus_rd_i && hit) begin
      for (int i = 0; i < NCH; i++) begin
        if (ch == CH_W'(i)) begin
          case (sel)
            SEL_PRESCALE: rdata_o = DATA_W'(rb_ps[i]);
            SEL_MODULUS:  rdata_o = DATA_W'(rb_mod[i]);
            SEL_DUTY:     rdata_o = DATA_W'(rb_duty[i]);
            SEL_ENABLE:   rdata_o = DATA_W'(rb_en[i]);
            default:      rdata_o = '0;
          endcase
        end
      end
    end
  end

  assert_unmapped_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd_i && !hit) |-> (rdata_o == '0));

  assert_quiet_rdata_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_rd_i |-> (rdata_o == '0));

endmodule

// File: tb/pwm_bank_tb.sv
`timescale 1ns/1ps
module pwm_bank_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [6:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  pwm;

  always #2.5 clk = ~clk;

  pwm_bank u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(bus_wr), .bus_rd_i(bus_rd),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .pwm_o(pwm)
  );

  int checks = 0;
  int errors = 0;
  string tag = "R3";

  // Reference model: position within period, staged and active settings.
  int m_en[4], m_c[4], s_ps[4], s_mod[4], s_duty[4];
  int a_ps[4], a_mod[4], a_duty[4], pend[4];

  function automatic int per_len(int ch);
    return (a_ps[ch] + 1) * ((a_mod[ch] == 0) ? 1 : a_mod[ch]);
  endfunction

  function automatic int high_len(int ch);
    if (a_mod[ch] == 0) return 0;
    return (a_ps[ch] + 1) * ((a_duty[ch] < a_mod[ch]) ? a_duty[ch] : a_mod[ch]);
  endfunction

  function automatic logic [3:0] exp_pwm();
    logic [3:0] v;
    for (int c = 0; c < 4; c++) v[c] = (m_en[c] != 0) && (m_c[c] < high_len(c));
    return v;
  endfunction

  function automatic logic [6:0] adr(int ch, int off);
    return {ch[1:0], off[4:0]};
  endfunction

  task automatic model_step(logic w, logic [6:0] a, logic [31:0] d);
    for (int c = 0; c < 4; c++) begin
      logic hitc, stop, ld;
      int at_end;
      hitc = w && (int'(a[6:5]) == c);
      stop = hitc && (a[4:0] == 5'h18) && !d[0];
      at_end = (m_en[c] != 0) && (m_c[c] == per_len(c) - 1);
      ld = (pend[c] != 0) && ((m_en[c] == 0) || (at_end != 0));
      if ((m_en[c] != 0) && !stop) m_c[c] = (at_end != 0) ? 0 : m_c[c] + 1;
      else m_c[c] = 0;
      if (ld) begin
        a_ps[c] = s_ps[c]; a_mod[c] = s_mod[c]; a_duty[c] = s_duty[c]; pend[c] = 0;
      end
      if (hitc) begin
        case (a[4:0])
          5'h00: s_ps[c]   = int'(d[7:0]);
          5'h04: s_mod[c]  = int'(d[7:0]);
          5'h08: begin s_duty[c] = int'(d[15:0]); pend[c] = 1; end
          5'h18: m_en[c]   = int'(d[0]);
          default: ;
        endcase
      end
    end
  endtask

  task automatic chk_out();
    logic [3:0] e;
    e = exp_pwm();
    checks++;
    if (pwm !== e) begin
      errors++;
      $display("FAIL %s pwm_o got %b expected %b at %0t", tag, pwm, e, $time);
    end
  endtask

  // One clock: drive at negedge, model the edge, compare at the next negedge.
  task automatic cyc(logic w, logic [6:0] a, logic [31:0] d);
    bus_wr = w; addr = a; wdata = d;
    @(posedge clk);
    model_step(w, a, d);
    @(negedge clk);
    bus_wr = 1'b0;
    chk_out();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 7'h0, 32'h0);
  endtask

  task automatic wr(int ch, int off, logic [31:0] d);
    cyc(1'b1, adr(ch, off), d);
  endtask

  task automatic rchk(logic [6:0] a, logic [31:0] e);
    bus_rd = 1'b1; addr = a;
    #1;
    checks++;
    if (rdata !== e) begin
      errors++;
      $display("FAIL %s read addr %h got %h expected %h", tag, a, rdata, e);
    end
    bus_rd = 1'b0;
  endtask

  task automatic cfg(int ch, int ps, int m, int d);
    wr(ch, 5'h00, ps);
    wr(ch, 5'h04, m);
    wr(ch, 5'h08, d);
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < 4; c++) begin
      m_en[c] = 0; m_c[c] = 0; s_ps[c] = 0; s_mod[c] = 0; s_duty[c] = 0;
      a_ps[c] = 0; a_mod[c] = 0; a_duty[c] = 0; pend[c] = 0;
    end

    // R3: reset state
    tag = "R3";
    repeat (3) @(negedge clk);
    chk_out();
    for (int c = 0; c < 4; c++) begin
      rchk(adr(c, 5'h00), 0); rchk(adr(c, 5'h04), 0);
      rchk(adr(c, 5'h08), 0); rchk(adr(c, 5'h18), 0);
    end
    rst_n = 1'b1;
    idle(2);

    // R1: readback with field masking
    tag = "R1";
    for (int c = 0; c < 4; c++) begin
      wr(c, 5'h00, 32'hFFFF_FF10 + c);
      wr(c, 5'h04, 32'hABCD_0020 + c);
      wr(c, 5'h08, 32'h5A5A_1230 + c);
      wr(c, 5'h18, 32'hFFFF_FFFE);
    end
    idle(1);
    for (int c = 0; c < 4; c++) begin
      rchk(adr(c, 5'h00), 32'h10 + c);
      rchk(adr(c, 5'h04), 32'h20 + c);
      rchk(adr(c, 5'h08), 32'h1230 + c);
      rchk(adr(c, 5'h18), 32'h0);
    end

    // R2: unmapped offsets
    tag = "R2";
    wr(1, 5'h0C, 32'hFFFF_FFFF); wr(1, 5'h10, 32'hFFFF_FFFF);
    wr(1, 5'h14, 32'hFFFF_FFFF); wr(1, 5'h1C, 32'hFFFF_FFFF);
    wr(1, 5'h01, 32'hFFFF_FFFF); wr(1, 5'h19, 32'hFFFF_FFFF);
    idle(3);
    rchk(adr(1, 5'h0C), 0); rchk(adr(1, 5'h10), 0); rchk(adr(1, 5'h14), 0);
    rchk(adr(1, 5'h1C), 0); rchk(adr(1, 5'h01), 0); rchk(adr(1, 5'h19), 0);
    rchk(adr(1, 5'h00), 32'h11); rchk(adr(1, 5'h04), 32'h21);
    rchk(adr(1, 5'h08), 32'h1231); rchk(adr(1, 5'h18), 0);

    // R4 R5 R6: sweep on channel 0; outputs checked every cycle
    for (int ps = 0; ps < 3; ps++) begin
      for (int mi = 0; mi < 5; mi++) begin
        int m;
        m = (mi == 4) ? 5 : mi;
        for (int d = 0; d <= m + 1; d++) begin
          tag = "R4 disabled during setup";
          cfg(0, ps, m, d);
          idle(1);
          tag = (d == 0 || m == 0 || d >= m) ? "R6 constant level" : "R5 period and high time";
          wr(0, 5'h18, 1);
          idle(2 * (ps + 1) * ((m == 0) ? 1 : m) + 3);
          tag = "R10 stop";
          wr(0, 5'h18, 0);
          idle(1);
        end
      end
    end

    // R7: staged prescale/modulus do not take effect
    tag = "R7";
    cfg(1, 1, 4, 2);
    idle(1);
    wr(1, 5'h18, 1);
    idle(5);
    wr(1, 5'h00, 0);
    wr(1, 5'h04, 3);
    idle(30);
    rchk(adr(1, 5'h00), 0);
    rchk(adr(1, 5'h04), 3);

    // R8: commit in mid-period switches at the boundary
    tag = "R8";
    idle(3);
    wr(1, 5'h08, 1);
    idle(25);
    wr(1, 5'h00, 2); wr(1, 5'h04, 6); wr(1, 5'h08, 4);
    idle(40);

    // R9: commit while disabled, then enable
    tag = "R9";
    wr(1, 5'h18, 0);
    cfg(1, 0, 3, 2);
    idle(2);
    wr(1, 5'h18, 1);
    idle(12);
    wr(1, 5'h18, 0);

    // R10: immediate stop of a full-duty channel, then restart
    tag = "R10";
    cfg(3, 2, 5, 5);
    idle(1);
    wr(3, 5'h18, 1);
    idle(7);
    wr(3, 5'h18, 0);
    idle(3);
    wr(3, 5'h18, 1);
    idle(4);
    cfg(3, 1, 4, 3);
    idle(2);
    wr(3, 5'h18, 0);
    idle(2);
    wr(3, 5'h18, 1);
    idle(20);

    // R11: all channels running with distinct settings
    tag = "R11";
    cfg(0, 0, 7, 3);
    cfg(1, 1, 5, 1);
    cfg(2, 2, 3, 2);
    cfg(3, 0, 4, 9);
    idle(1);
    wr(0, 5'h18, 1); wr(2, 5'h18, 1); wr(1, 5'h18, 1);
    idle(9);
    wr(3, 5'h18, 1);
    idle(20);
    wr(2, 5'h04, 6); wr(2, 5'h08, 5);
    idle(30);
    wr(1, 5'h18, 0);
    idle(30);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule